// File: doc/BRIEF.md
# Character-LCD Parallel Bus Controller

The controller runs single accesses to one of two character-display controllers over an asynchronous parallel bus. A host raises a one-cycle request with a two-bit operation code, a target select and a data byte. The block then sequences the register-select, read/write and enable lines and the data-bus output enable through four phases: setup, strobe, hold and a trailing chip-select delay. Each phase length is a count of memory-clock cycles. Reads and writes have their own setup, strobe and hold counts, and both share the chip-select delay.

A read releases the data bus for the whole access. It captures the low byte of the returned bus on the final strobe cycle and reports it with a one-cycle done pulse. A write drives the byte on the low eight bus bits and holds the upper bits at zero. Every pin the block drives is decoded from registered state, so it changes only at a rising clock edge.

Top module: `lcd_char_bus_ctrl`

## Requirements
- R1: `req_op_i[0]` sets `lcd_rs_o` and `req_op_i[1]` sets `lcd_rw_o` (1 = read). Both are latched when a request is accepted and stay unchanged until the next accepted request.
- R2: A request is accepted at a rising edge when `req_i` is high and `busy_o` is low. `busy_o` is then high for exactly S+P'+H'+C cycles. A request raised while `busy_o` is high is ignored and never starts an access.
- R3: The enable rises S cycles after the acceptance edge, where S is the setup count (0..31) of the access direction. With S = 0 the enable rises at the acceptance edge itself. Read and write counts are independent.
- R4: Only the enable chosen by `req_cs_i` is high (0 selects `lcd_e_o[0]`, 1 selects `lcd_e_o[1]`). It stays high for P' = max(P,1) consecutive cycles, where P is the strobe count (0..63). Both enables are low outside the strobe phase.
- R5: After the enable falls, the hold phase lasts H' = max(H,1) cycles, where H is the hold count (0..15).
- R6: After the hold phase, a chip-select delay of C cycles (0..3) follows with both enables low. Only after it does `busy_o` fall.
- R7: During a write, `lcd_d_oe_o` is high and `lcd_d_o` equals {8'h00, data byte} from acceptance through the hold phase.
- R8: During a read, `lcd_d_oe_o` is low from acceptance through the hold phase. It is high again in the chip-select delay and while idle.
- R9: On a read, `rd_data_o` takes `lcd_d_i[7:0]` at the edge that ends the last strobe cycle, and `done_o` is high for exactly that one following cycle. Writes never raise `done_o`.
- R10: During reset `busy_o`, `done_o`, `lcd_e_o`, `lcd_rs_o`, `lcd_rw_o`, `lcd_d_o` and `rd_data_o` are zero, and `lcd_d_oe_o` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| req_op_i | input | 2 | Bit 0 register select, bit 1 read |
| req_cs_i | input | 1 | Target display select |
| req_data_i | input | 8 | Write byte |
| cfg_wr_setup_i | input | 5 | Write setup cycles |
| cfg_wr_strobe_i | input | 6 | Write strobe cycles |
| cfg_wr_hold_i | input | 4 | Write hold cycles |
| cfg_rd_setup_i | input | 5 | Read setup cycles |
| cfg_rd_strobe_i | input | 6 | Read strobe cycles |
| cfg_rd_hold_i | input | 4 | Read hold cycles |
| cfg_cs_delay_i | input | 2 | Trailing chip-select delay cycles |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 8 | Captured read byte |
| lcd_rs_o | output | 1 | Register select |
| lcd_rw_o | output | 1 | Read/write line |
| lcd_e_o | output | 2 | Enable strobes, one per display |
| lcd_d_o | output | 16 | Data bus out |
| lcd_d_oe_o | output | 1 | Data bus output enable |
| lcd_d_i | input | 16 | Data bus in |

## Verification
The assertions assume that the phase-count inputs stay constant while `busy_o` is high, because the counter reloads from them at every phase boundary. The stimulus changes the configuration only while the block is idle. It raises `req_i` for a single cycle away from the clock edge. The stray request sent during a busy access carries a different operation code, so any acceptance would show up as a register-select change or a longer busy window.

// File: rtl/lcd_bus_pkg.sv
`timescale 1ns/1ps
package lcd_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_CSD
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_phase_len.sv
`timescale 1ns/1ps
module lcd_phase_len #(
  parameter int SETUP_W  = 5,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4,
  parameter int CSD_W    = 2,
  parameter int CNT_W    = 6
) (
  input  logic                rw_i,
  input  logic [SETUP_W-1:0]  wr_setup_i,
  input  logic [STROBE_W-1:0] wr_strobe_i,
  input  logic [HOLD_W-1:0]   wr_hold_i,
  input  logic [SETUP_W-1:0]  rd_setup_i,
  input  logic [STROBE_W-1:0] rd_strobe_i,
  input  logic [HOLD_W-1:0]   rd_hold_i,
  input  logic [CSD_W-1:0]    csd_i,
  output logic [CNT_W-1:0]    setup_len_o,
  output logic [CNT_W-1:0]    strobe_len_o,
  output logic [CNT_W-1:0]    hold_len_o,
  output logic [CNT_W-1:0]    csd_len_o
);
  logic [SETUP_W-1:0]  setup_sel;
  logic [STROBE_W-1:0] strobe_sel;
  logic [HOLD_W-1:0]   hold_sel;

  always_comb begin
    setup_sel  = rw_i ? rd_setup_i  : wr_setup_i;
    strobe_sel = rw_i ? rd_strobe_i : wr_strobe_i;
    hold_sel   = rw_i ? rd_hold_i   : wr_hold_i;
    setup_len_o = CNT_W'(setup_sel);
    csd_len_o   = CNT_W'(csd_i);
    // strobe and hold never shorter than one cycle
    strobe_len_o = (strobe_sel == '0) ? CNT_W'(1) : CNT_W'(strobe_sel);
    hold_len_o   = (hold_sel == '0)   ? CNT_W'(1) : CNT_W'(hold_sel);
  end
endmodule

// File: rtl/lcd_phase_seq.sv
`timescale 1ns/1ps
module lcd_phase_seq
  import lcd_bus_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] strobe_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  logic [CNT_W-1:0] csd_len_i,
  output phase_e           phase_o,
  output logic             last_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign phase_o = phase_q;
  assign last_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          if (setup_len_i != '0) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_len_i - 1'b1;
          end else begin
            phase_q <= PH_STROBE;
            cnt_q   <= strobe_len_i - 1'b1;
          end
        end
        PH_SETUP: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else begin
          phase_q <= PH_STROBE;
          cnt_q   <= strobe_len_i - 1'b1;
        end
        PH_STROBE: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_len_i - 1'b1;
        end
        PH_HOLD: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else if (csd_len_i != '0) begin
          phase_q <= PH_CSD;
          cnt_q   <= csd_len_i - 1'b1;
        end else begin
          phase_q <= PH_IDLE;
        end
        PH_CSD: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else phase_q <= PH_IDLE;
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_char_bus_ctrl.sv
`timescale 1ns/1ps
module lcd_char_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_W  = 5,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4,
  parameter int CSD_W    = 2,
  parameter int DATA_W   = 16,
  parameter int CHAR_W   = 8,
  parameter int NUM_E    = 2,
  localparam int CS_W    = $clog2(NUM_E),
  localparam int CNT_W   = max2(max2(SETUP_W, STROBE_W), max2(HOLD_W, CSD_W))
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [1:0]          req_op_i,
  input  logic [CS_W-1:0]     req_cs_i,
  input  logic [CHAR_W-1:0]   req_data_i,
  input  logic [SETUP_W-1:0]  cfg_wr_setup_i,
  input  logic [STROBE_W-1:0] cfg_wr_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_wr_hold_i,
  input  logic [SETUP_W-1:0]  cfg_rd_setup_i,
  input  logic [STROBE_W-1:0] cfg_rd_strobe_i,
  input  logic [HOLD_W-1:0]   cfg_rd_hold_i,
  input  logic [CSD_W-1:0]    cfg_cs_delay_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CHAR_W-1:0]   rd_data_o,
  output logic                lcd_rs_o,
  output logic                lcd_rw_o,
  output logic [NUM_E-1:0]    lcd_e_o,
  output logic [DATA_W-1:0]   lcd_d_o,
  output logic                lcd_d_oe_o,
  input  logic [DATA_W-1:0]   lcd_d_i
);
  phase_e           phase;
  logic             last;
  logic             accept;
  logic             rs_q, rw_q;
  logic [CS_W-1:0]  cs_q;
  logic [CHAR_W-1:0] wdata_q;
  logic [CNT_W-1:0] setup_len, strobe_len, hold_len, csd_len;
  logic             active;

  assign accept = req_i && (phase == PH_IDLE);

  lcd_phase_len #(
    .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W),
    .CSD_W(CSD_W), .CNT_W(CNT_W)
  ) u_len (
    .rw_i        (accept ? req_op_i[1] : rw_q),
    .wr_setup_i  (cfg_wr_setup_i),
    .wr_strobe_i (cfg_wr_strobe_i),
    .wr_hold_i   (cfg_wr_hold_i),
    .rd_setup_i  (cfg_rd_setup_i),
    .rd_strobe_i (cfg_rd_strobe_i),
    .rd_hold_i   (cfg_rd_hold_i),
    .csd_i       (cfg_cs_delay_i),
    .setup_len_o (setup_len),
    .strobe_len_o(strobe_len),
    .hold_len_o  (hold_len),
    .csd_len_o   (csd_len)
  );

  lcd_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .setup_len_i (setup_len),
    .strobe_len_i(strobe_len),
    .hold_len_i  (hold_len),
    .csd_len_i   (csd_len),
    .phase_o     (phase),
    .last_o      (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      cs_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      rs_q    <= req_op_i[0];
      rw_q    <= req_op_i[1];
      cs_q    <= req_cs_i;
      wdata_q <= req_data_i;
    end
  end

  // capture on the edge closing the final strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (phase == PH_STROBE && last && rw_q) begin
        rd_data_o <= lcd_d_i[CHAR_W-1:0];
        done_o    <= 1'b1;
      end
    end
  end

  assign active     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign busy_o     = (phase != PH_IDLE);
  assign lcd_rs_o   = rs_q;
  assign lcd_rw_o   = rw_q;
  assign lcd_d_oe_o = !(active && rw_q);
  assign lcd_d_o    = {{(DATA_W-CHAR_W){1'b0}}, wdata_q};

  for (genvar g = 0; g < NUM_E; g++) begin : g_en
    assign lcd_e_o[g] = (phase == PH_STROBE) && (cs_q == CS_W'(g));
  end
endmodule

// File: rtl/lcd_char_bus_ctrl_chk.sv
`timescale 1ns/1ps
module lcd_char_bus_ctrl_chk #(
  parameter int SETUP_W  = 5,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4,
  parameter int CSD_W    = 2,
  parameter int DATA_W   = 16,
  parameter int CHAR_W   = 8,
  parameter int NUM_E    = 2,
  localparam int CS_W    = $clog2(NUM_E)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic [1:0]          req_op_i,
  input logic [CS_W-1:0]     req_cs_i,
  input logic [CHAR_W-1:0]   req_data_i,
  input logic [SETUP_W-1:0]  cfg_wr_setup_i,
  input logic [STROBE_W-1:0] cfg_wr_strobe_i,
  input logic [HOLD_W-1:0]   cfg_wr_hold_i,
  input logic [SETUP_W-1:0]  cfg_rd_setup_i,
  input logic [STROBE_W-1:0] cfg_rd_strobe_i,
  input logic [HOLD_W-1:0]   cfg_rd_hold_i,
  input logic [CSD_W-1:0]    cfg_cs_delay_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [CHAR_W-1:0]   rd_data_o,
  input logic                lcd_rs_o,
  input logic                lcd_rw_o,
  input logic [NUM_E-1:0]    lcd_e_o,
  input logic [DATA_W-1:0]   lcd_d_o,
  input logic                lcd_d_oe_o,
  input logic [DATA_W-1:0]   lcd_d_i
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o); // R2
  AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o))); // R1
  AST_ENABLE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lcd_e_o)); // R4
  AST_ENABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lcd_e_o) |-> busy_o); // R4
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|lcd_e_o) |-> busy_o); // R5
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_rw_o && (|lcd_e_o)) |-> !lcd_d_oe_o); // R8
  AST_IDLE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (lcd_d_oe_o && lcd_e_o == '0)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lcd_rw_o && busy_o && lcd_e_o == '0)); // R9
endmodule

bind lcd_char_bus_ctrl lcd_char_bus_ctrl_chk #(
  .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .CSD_W(CSD_W),
  .DATA_W(DATA_W), .CHAR_W(CHAR_W), .NUM_E(NUM_E)
) u_chk (.*);

// File: tb/lcd_char_bus_ctrl_test.sv
`timescale 1ns/1ps
module lcd_char_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  req_op = '0;
  logic        req_cs = 1'b0;
  logic [7:0]  req_data = '0;
  logic [4:0]  wr_setup = '0, rd_setup = '0;
  logic [5:0]  wr_strobe = 6'd1, rd_strobe = 6'd1;
  logic [3:0]  wr_hold = 4'd1, rd_hold = 4'd1;
  logic [1:0]  cs_delay = '0;
  logic        busy, done, rs, rw, d_oe;
  logic [7:0]  rd_data;
  logic [1:0]  en;
  logic [15:0] d_out;
  logic [15:0] d_in = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcd_char_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_op_i(req_op), .req_cs_i(req_cs),
    .req_data_i(req_data), .cfg_wr_setup_i(wr_setup), .cfg_wr_strobe_i(wr_strobe),
    .cfg_wr_hold_i(wr_hold), .cfg_rd_setup_i(rd_setup), .cfg_rd_strobe_i(rd_strobe),
    .cfg_rd_hold_i(rd_hold), .cfg_cs_delay_i(cs_delay), .busy_o(busy), .done_o(done),
    .rd_data_o(rd_data), .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_e_o(en), .lcd_d_o(d_out),
    .lcd_d_oe_o(d_oe), .lcd_d_i(d_in)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // one access, observed at every falling edge while busy
  task automatic run_access(input bit [1:0] op, input bit cs, input bit [7:0] wd,
                            input bit [7:0] va, input bit [7:0] vb,
                            input int s, input int p, input int h, input int c,
                            input bit stray);
    int pe, he, idx, first_e, ecnt, after, bad_ctl, bad_en, bad_bus, dones, done_idx;
    bit seen_e;
    bit [7:0] cap;
    pe = (p == 0) ? 1 : p;
    he = (h == 0) ? 1 : h;
    if (op[1]) begin
      rd_setup = 5'(s); rd_strobe = 6'(p); rd_hold = 4'(h);
      wr_setup = 5'd7;  wr_strobe = 6'd9;  wr_hold = 4'd5;
    end else begin
      wr_setup = 5'(s); wr_strobe = 6'(p); wr_hold = 4'(h);
      rd_setup = 5'd6;  rd_strobe = 6'd11; rd_hold = 4'd4;
    end
    cs_delay = 2'(c);
    d_in = {8'hA5, va};
    @(negedge clk);
    req = 1'b1; req_op = op; req_cs = cs; req_data = wd;
    @(negedge clk);
    req = 1'b0;
    idx = 0; first_e = -1; ecnt = 0; after = 0; seen_e = 0;
    bad_ctl = 0; bad_en = 0; bad_bus = 0; dones = 0; done_idx = -1; cap = '0;
    while (busy && idx < 400) begin
      if (stray && idx == 1) begin req = 1'b1; req_op = ~op; req_cs = ~cs; end
      if (stray && idx == 2) req = 1'b0;
      if (rs != op[0] || rw != op[1]) bad_ctl++;
      if (en != 2'b00) begin
        if (first_e < 0) first_e = idx;
        ecnt++;
        seen_e = 1;
        if (en != (2'b01 << cs)) bad_en++;
      end else if (seen_e) begin
        after++;
        d_in = {8'h5A, vb};
      end
      if (op[1]) begin
        if (d_oe != (idx >= s + pe + he)) bad_bus++;
      end else if (!d_oe || d_out != {8'h00, wd}) bad_bus++;
      if (done) begin dones++; done_idx = idx; cap = rd_data; end
      @(negedge clk);
      idx++;
    end
    check(idx == s + pe + he + c, "R2", "busy cycles", idx, s + pe + he + c);
    check(first_e == s, "R3", "setup cycles before enable", first_e, s);
    check(ecnt == pe, "R4", "enable cycles", ecnt, pe);
    check(bad_en == 0, "R4", "wrong enable cycles", bad_en, 0);
    check(after == he + c, "R5", "hold plus delay cycles", after, he + c);
    check(bad_ctl == 0, "R1", "rs/rw mismatch cycles", bad_ctl, 0);
    check(bad_bus == 0, op[1] ? "R8" : "R7", "bus drive mismatch cycles", bad_bus, 0);
    if (op[1]) begin
      check(dones == 1, "R9", "done pulses", dones, 1);
      check(done_idx == s + pe, "R9", "done cycle", done_idx, s + pe);
      check(cap == va, "R9", "captured byte", cap, va);
    end else begin
      check(dones == 0, "R9", "done pulses on write", dones, 0);
    end
    repeat (3) begin
      check(!busy && en == 2'b00, "R2", "idle after access", busy, 0);
      check(d_oe, "R8", "bus driven when idle", d_oe, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    #5;
    check(busy == 0 && done == 0 && en == 0, "R10", "busy/done/enable in reset",
          {busy, done, en}, 0);
    check(rs == 0 && rw == 0 && d_out == 0 && rd_data == 0, "R10", "ctl/data in reset",
          {rs, rw, d_out}, 0);
    check(d_oe == 1, "R10", "bus enable in reset", d_oe, 1);
  endtask

  task automatic t_write_data;      // R7 R6 C=1
    run_access(2'b01, 1'b0, 8'h3C, 8'h00, 8'h00, 2, 3, 1, 1, 1'b0);
  endtask

  task automatic t_write_cmd_nosetup; // R3 S=0, R6 C=0
    run_access(2'b00, 1'b1, 8'h81, 8'h00, 8'h00, 0, 1, 2, 0, 1'b0);
  endtask

  task automatic t_read_status;     // R9 R8 C=3
    run_access(2'b10, 1'b0, 8'h00, 8'hC7, 8'h18, 1, 4, 2, 3, 1'b0);
  endtask

  task automatic t_read_clamped;    // R4 R5 zero counts
    run_access(2'b11, 1'b1, 8'h00, 8'h6E, 8'h91, 3, 0, 0, 2, 1'b0);
  endtask

  task automatic t_busy_ignore;     // R2 stray request
    run_access(2'b01, 1'b0, 8'hE4, 8'h00, 8'h00, 4, 2, 3, 1, 1'b1);
  endtask

  task automatic t_max_counts;      // R3 R4 R5 R6 maxima
    run_access(2'b00, 1'b0, 8'h7F, 8'h00, 8'h00, 31, 63, 15, 3, 1'b0);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_write_data();
    t_write_cmd_nosetup();
    t_read_status();
    t_read_clamped();
    t_busy_ignore();
    t_max_counts();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule